// File: doc/BRIEF.md
# Calendar Clock With Alarm

This block keeps wall-clock time and a calendar inside a larger chip. Seconds, minutes, hours, day of week, day of month, month and two-digit year are held as bytes behind a small synchronous register port. The port has a 4-bit address, write data, a write strobe and combinational read data. Three further bytes hold an alarm time in seconds, minutes and hours. A mode byte sets whether the clock runs, whether the bytes use packed-decimal (BCD) or plain binary, and whether hours count over 24 or over 12 with a PM flag.

A strobe input carries the 32.768 kHz time base. A prescaler divides it to one tick per second. When the clock runs, each tick starts a two-cycle update. In the first cycle, a status bit reports that the update is in progress. In the second cycle, all carries are applied at once. The block then pulses an update-ended output. In that same cycle it pulses an alarm output if the new time equals all three alarm bytes.

Software stops the clock, writes a full time and date, then starts the clock again. A mode change does not convert the bytes already stored. Software writes them in the new encoding.

Top module: `rtc_calendar_core`

## Requirements
- R1: Address map: 0h seconds, 1h alarm seconds, 2h minutes, 3h alarm minutes, 4h hours, 5h alarm hours, 6h day of week, 7h date, 8h month, 9h year, Ah status, Bh mode. Addresses Ch–Fh read 00h and ignore writes. Writes to the status byte are ignored.
- R2: Bit 7 of a write to the seconds byte is dropped, and that bit always reads 0.
- R3: Mode byte: bit 7 is run, bit 2 selects binary (1) or BCD (0), bit 1 selects 24-hour (1) or 12-hour (0). After reset: mode 02h, time 00:00:00, day of week 1, date 1, month 1, year 0, alarm bytes 00h.
- R4: A one-second tick occurs after every PRESCALE time-base strobes. While run is set, status bit 7 reads 1 in the cycle after the tick and reads 0 otherwise. The new time appears one cycle later.
- R5: While run is clear, ticks cause no update, no in-progress flag and no update-ended pulse. The time bytes keep their values.
- R6: In BCD mode each field counts in decimal with a carry per nibble (09h→10h). In binary mode it counts plainly (09h→0Ah).
- R7: Seconds roll 59→0 and carry into minutes. Minutes roll 59→0 and carry into hours. Hours roll from 23 to 0 and carry into the date. The date rolls to 1 and carries into the month. The month rolls 12→1 and carries into the year. The year rolls 99→0.
- R8: Month length is 31, or 30 for months 4, 6, 9 and 11. February has 29 days when the year is divisible by 4, and 28 otherwise.
- R9: In 12-hour mode, hours run 1–12 and bit 7 is set for PM. Crossing 11:59:59 gives 12 with PM set (92h in BCD). Crossing 12:59:59 gives 1 with the same half-day. Crossing 11:59:59 PM gives 12 with PM clear (12h in BCD) and advances the date.
- R10: Day of week counts 1–7, advances on each date rollover and wraps 7→1.
- R11: The update-ended output is high for exactly one cycle, in the cycle right after the in-progress cycle.
- R12: The alarm output pulses with update-ended only when the updated seconds, minutes and hours all equal their alarm bytes. Any single mismatch suppresses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per period of the 32.768 kHz time base |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| update_end | output | 1 | One-cycle pulse after each applied update |
| alarm_hit | output | 1 | One-cycle pulse when the updated time matches the alarm |

## Verification
The assertions assume PRESCALE is at least 2, so two seconds ticks never arrive on adjacent cycles. They also assume that only an applied update or a bus write to one of the seven time addresses can change a time byte. The bench writes only legal field values in the encoding that is active at the time. It changes modes only while the clock is stopped. Random trials pick fields weighted toward 59, 23, 11 and end-of-month values, so every carry and wrap path gets exercised. Each trial releases exactly PRESCALE strobes, which produces one tick per simulated second.

// File: rtl/rtc_cal_pkg.sv
// Package: shared address map, mode bit positions, time record type and
// the conversion helpers between bus encoding and plain numbers.
// Assumes all field values fit in 7 bits (largest legal value is 99).
package rtc_cal_pkg;

    localparam int RTC_AW = 4;
    localparam int RTC_DW = 8;
    localparam int FW     = 7;

    localparam logic [RTC_AW-1:0] A_SEC     = 4'h0;
    localparam logic [RTC_AW-1:0] A_ALM_SEC = 4'h1;
    localparam logic [RTC_AW-1:0] A_MIN     = 4'h2;
    localparam logic [RTC_AW-1:0] A_ALM_MIN = 4'h3;
    localparam logic [RTC_AW-1:0] A_HR      = 4'h4;
    localparam logic [RTC_AW-1:0] A_ALM_HR  = 4'h5;
    localparam logic [RTC_AW-1:0] A_DOW     = 4'h6;
    localparam logic [RTC_AW-1:0] A_DATE    = 4'h7;
    localparam logic [RTC_AW-1:0] A_MON     = 4'h8;
    localparam logic [RTC_AW-1:0] A_YEAR    = 4'h9;
    localparam logic [RTC_AW-1:0] A_STAT    = 4'hA;
    localparam logic [RTC_AW-1:0] A_MODE    = 4'hB;

    localparam int MB_RUN = 7;
    localparam int MB_BIN = 2;
    localparam int MB_H24 = 1;
    localparam logic [RTC_DW-1:0] MODE_RST = 8'h02;

    typedef struct packed {
        logic [FW-1:0]     sec;
        logic [RTC_DW-1:0] min;
        logic [RTC_DW-1:0] hr;
        logic [RTC_DW-1:0] dow;
        logic [RTC_DW-1:0] date;
        logic [RTC_DW-1:0] mon;
        logic [RTC_DW-1:0] yr;
    } rtc_time_t;

    // Bus byte to plain number.
    function automatic logic [FW-1:0] rtc_to_num(input logic [RTC_DW-1:0] v, input logic bin);
        logic [FW-1:0] tens;
        logic [FW-1:0] ones;
        tens = {3'b000, v[7:4]};
        ones = {3'b000, v[3:0]};
        return bin ? v[FW-1:0] : (tens * 7'd10 + ones);
    endfunction

    // Plain number to bus byte.
    function automatic logic [RTC_DW-1:0] rtc_from_num(input logic [FW-1:0] n, input logic bin);
        logic [FW-1:0] t;
        logic [FW-1:0] o;
        t = n / 7'd10;
        o = n % 7'd10;
        return bin ? {1'b0, n} : {t[3:0], o[3:0]};
    endfunction

    // Hour byte to 0..23.
    function automatic logic [FW-1:0] rtc_hr_to24(input logic [RTC_DW-1:0] v, input logic bin,
                                                  input logic h24);
        logic [FW-1:0] h;
        if (h24) return rtc_to_num(v, bin);
        h = rtc_to_num({1'b0, v[6:0]}, bin);
        if (h == 7'd12) h = 7'd0;
        if (v[7]) h = h + 7'd12;
        return h;
    endfunction

    // 0..23 to hour byte in the selected format.
    function automatic logic [RTC_DW-1:0] rtc_hr_from24(input logic [FW-1:0] h, input logic bin,
                                                        input logic h24);
        logic [FW-1:0]     hh;
        logic [RTC_DW-1:0] e;
        if (h24) return rtc_from_num(h, bin);
        hh = (h >= 7'd12) ? h - 7'd12 : h;
        if (hh == 7'd0) hh = 7'd12;
        e = rtc_from_num(hh, bin);
        return {(h >= 7'd12), e[6:0]};
    endfunction

    // Days in a month; leap when year is a multiple of four.
    function automatic logic [FW-1:0] rtc_month_len(input logic [FW-1:0] mon, input logic [FW-1:0] yr);
        case (mon)
            7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: divides the time-base strobe down to a one-cycle seconds tick.
// Assumes PRESCALE >= 2; the count advances only on ref_tick.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic sec_tick
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;
    logic          tick_q;

    // Count strobes and emit a tick on the last one of each group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (ref_tick) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign sec_tick = tick_q;

    assert_tick_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

endmodule

// File: rtl/rtc_time_engine.sv
// Module: holds the seven time bytes, applies bus writes and performs the
// two-cycle update (flag cycle, then apply all carries in one step).
// Assumes stored values are legal for the active encoding; the update
// takes priority over a bus write in the apply cycle.
module rtc_time_engine
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              run_en,
    input  logic              bin_mode,
    input  logic              h24_mode,
    input  logic              wr_en,
    input  logic [RTC_AW-1:0] wr_addr,
    input  logic [RTC_DW-1:0] wr_data,
    output rtc_time_t         time_o,
    output rtc_time_t         next_o,
    output logic              uip_o,
    output logic              done_o
);
    rtc_time_t cur_q;
    rtc_time_t nxt;
    logic      uip_q;
    logic      done_q;
    logic      time_wr;

    logic [FW-1:0] s, m, h, dw, d, mo, y, dim;
    logic          c_s, c_m, c_h, c_d, c_mo;
    logic [FW-1:0] ns, nm, nh, nd, ndw, nmo, ny;
    logic [RTC_DW-1:0] es;

    // Decode current fields and build the incremented time with carries.
    always_comb begin
        s   = rtc_to_num({1'b0, cur_q.sec}, bin_mode);
        m   = rtc_to_num(cur_q.min, bin_mode);
        h   = rtc_hr_to24(cur_q.hr, bin_mode, h24_mode);
        dw  = rtc_to_num(cur_q.dow, bin_mode);
        d   = rtc_to_num(cur_q.date, bin_mode);
        mo  = rtc_to_num(cur_q.mon, bin_mode);
        y   = rtc_to_num(cur_q.yr, bin_mode);
        dim = rtc_month_len(mo, y);

        c_s  = (s >= 7'd59);
        c_m  = c_s && (m >= 7'd59);
        c_h  = c_m && (h >= 7'd23);
        c_d  = c_h && (d >= dim);
        c_mo = c_d && (mo >= 7'd12);

        ns  = c_s  ? 7'd0 : s + 7'd1;
        nm  = c_m  ? 7'd0 : m + 7'd1;
        nh  = c_h  ? 7'd0 : h + 7'd1;
        nd  = c_d  ? 7'd1 : d + 7'd1;
        ndw = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
        nmo = c_mo ? 7'd1 : mo + 7'd1;
        ny  = (y >= 7'd99) ? 7'd0 : y + 7'd1;

        es       = rtc_from_num(ns, bin_mode);
        nxt.sec  = es[FW-1:0];
        nxt.min  = c_s  ? rtc_from_num(nm, bin_mode) : cur_q.min;
        nxt.hr   = c_m  ? rtc_hr_from24(nh, bin_mode, h24_mode) : cur_q.hr;
        nxt.dow  = c_h  ? rtc_from_num(ndw, bin_mode) : cur_q.dow;
        nxt.date = c_h  ? rtc_from_num(nd, bin_mode) : cur_q.date;
        nxt.mon  = c_d  ? rtc_from_num(nmo, bin_mode) : cur_q.mon;
        nxt.yr   = c_mo ? rtc_from_num(ny, bin_mode) : cur_q.yr;
    end

    // Flag which bus writes land on a time byte.
    always_comb begin
        time_wr = wr_en && (wr_addr == A_SEC || wr_addr == A_MIN || wr_addr == A_HR ||
                            wr_addr == A_DOW || wr_addr == A_DATE || wr_addr == A_MON ||
                            wr_addr == A_YEAR);
    end

    // Time byte storage: update has priority, otherwise accept writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.sec  <= '0;
            cur_q.min  <= 8'h00;
            cur_q.hr   <= 8'h00;
            cur_q.dow  <= 8'h01;
            cur_q.date <= 8'h01;
            cur_q.mon  <= 8'h01;
            cur_q.yr   <= 8'h00;
        end else if (uip_q) begin
            cur_q <= nxt;
        end else if (wr_en) begin
            case (wr_addr)
                A_SEC:   cur_q.sec  <= wr_data[FW-1:0];
                A_MIN:   cur_q.min  <= wr_data;
                A_HR:    cur_q.hr   <= wr_data;
                A_DOW:   cur_q.dow  <= wr_data;
                A_DATE:  cur_q.date <= wr_data;
                A_MON:   cur_q.mon  <= wr_data;
                A_YEAR:  cur_q.yr   <= wr_data;
                default: ;
            endcase
        end
    end

    // Update sequencing: in-progress cycle, then one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uip_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            uip_q  <= sec_tick && run_en;
            done_q <= uip_q;
        end
    end

    assign time_o = cur_q;
    assign next_o = nxt;
    assign uip_o  = uip_q;
    assign done_o = done_q;

    assert_uip_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uip_q |=> !uip_q);
    assert_uip_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uip_q |-> $past(run_en));
    assert_time_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip_q && !time_wr) |=> $stable(cur_q));
    assert_done_after_uip_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(uip_q));

endmodule

// File: rtl/rtc_alarm_match.sv
// Module: compares the candidate (post-update) seconds, minutes and hours
// with the three alarm bytes and registers a hit in the apply cycle.
// Assumes the candidate bytes are valid whenever apply is high.
module rtc_alarm_match
    import rtc_cal_pkg::*;
#(
    parameter int NFIELD = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          apply,
    input  logic [NFIELD-1:0][RTC_DW-1:0] cand,
    input  logic [NFIELD-1:0][RTC_DW-1:0] target,
    output logic                          hit_o
);
    logic [NFIELD-1:0] eq;
    logic              hit_q;

    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign eq[i] = (cand[i] == target[i]);
    end

    // Register a hit only when every field matches during an update.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= apply && (&eq);
    end

    assign hit_o = hit_q;

    assert_hit_needs_apply_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(apply));

endmodule

// File: rtl/rtc_calendar_core.sv
// Module: top of the calendar clock. Holds the mode and alarm bytes,
// wires prescaler, time engine and alarm comparator, and serves reads.
// Assumes the bus is synchronous to clk; reads are combinational.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        update_end,
    output logic        alarm_hit
);
    localparam int NALM = 3;

    logic                        sec_tick;
    logic [RTC_DW-1:0]           mode_q;
    logic [NALM-1:0][RTC_DW-1:0] alm_q;
    logic [NALM-1:0][RTC_DW-1:0] cand;
    rtc_time_t                   cur_t;
    rtc_time_t                   nxt_t;
    logic                        uip;
    logic                        done;

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .sec_tick (sec_tick)
    );

    rtc_time_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .run_en   (mode_q[MB_RUN]),
        .bin_mode (mode_q[MB_BIN]),
        .h24_mode (mode_q[MB_H24]),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .time_o   (cur_t),
        .next_o   (nxt_t),
        .uip_o    (uip),
        .done_o   (done)
    );

    // Mode byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                            mode_q <= MODE_RST;
        else if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata;
    end

    // Alarm bytes sit at odd addresses 1, 3, 5 (seconds, minutes, hours).
    for (genvar i = 0; i < NALM; i++) begin : g_alm
        localparam logic [RTC_AW-1:0] ADDR = RTC_AW'(2 * i + 1);
        // Store alarm byte i.
        always_ff @(posedge clk) begin
            if (!rst_n)                          alm_q[i] <= '0;
            else if (bus_wr && bus_addr == ADDR) alm_q[i] <= bus_wdata;
        end
    end

    assign cand[0] = {1'b0, nxt_t.sec};
    assign cand[1] = nxt_t.min;
    assign cand[2] = nxt_t.hr;

    rtc_alarm_match #(.NFIELD(NALM)) u_alm (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply  (uip),
        .cand   (cand),
        .target (alm_q),
        .hit_o  (alarm_hit)
    );

    // Read multiplexer over the address map.
    always_comb begin
        case (bus_addr)
            A_SEC:     bus_rdata = {1'b0, cur_t.sec};
            A_ALM_SEC: bus_rdata = alm_q[0];
            A_MIN:     bus_rdata = cur_t.min;
            A_ALM_MIN: bus_rdata = alm_q[1];
            A_HR:      bus_rdata = cur_t.hr;
            A_ALM_HR:  bus_rdata = alm_q[2];
            A_DOW:     bus_rdata = cur_t.dow;
            A_DATE:    bus_rdata = cur_t.date;
            A_MON:     bus_rdata = cur_t.mon;
            A_YEAR:    bus_rdata = cur_t.yr;
            A_STAT:    bus_rdata = {uip, 7'b0};
            A_MODE:    bus_rdata = mode_q;
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign update_end = done;

    assert_alarm_with_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> update_end);
    assert_seconds_msb_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SEC) |-> !bus_rdata[7]);

endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       update_end;
    logic       alarm_hit;

    int checks = 0;
    int errors = 0;

    int ms, mm, mh, mdw, md, mmo, my;
    bit mbin, mh24, mrun;
    logic [7:0] ab_s, ab_m, ab_h;

    always #2.5 clk = ~clk;

    rtc_calendar_core #(.PRESCALE(P)) i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .update_end(update_end), .alarm_hit(alarm_hit)
    );

    function automatic int dim_f(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] enc(int n, bit bin);
        if (bin) return 8'(n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [7:0] enc_hr(int h, bit bin, bit h24);
        int hh;
        if (h24) return enc(h, bin);
        hh = h % 12;
        if (hh == 0) hh = 12;
        return enc(hh, bin) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic model_tick();
        if (!mrun) return;
        if (ms >= 59) begin
            ms = 0;
            if (mm >= 59) begin
                mm = 0;
                if (mh >= 23) begin
                    mh = 0;
                    mdw = (mdw >= 7) ? 1 : mdw + 1;
                    if (md >= dim_f(mmo, my)) begin
                        md = 1;
                        if (mmo >= 12) begin
                            mmo = 1;
                            my = (my >= 99) ? 0 : my + 1;
                        end else mmo++;
                    end else md++;
                end else mh++;
            end else mm++;
        end else ms++;
    endtask

    task automatic set_mode(input bit run, input bit bin, input bit h24);
        mrun = run; mbin = bin; mh24 = h24;
        bus_write(4'hB, {run, 4'b0, bin, h24, 1'b0});
    endtask

    task automatic set_time(input bit bin, input bit h24, input int h, input int m, input int s,
                            input int dw, input int d, input int mo, input int y);
        set_mode(1'b0, bin, h24);
        ms = s; mm = m; mh = h; mdw = dw; md = d; mmo = mo; my = y;
        bus_write(4'h0, enc(s, bin));
        bus_write(4'h2, enc(m, bin));
        bus_write(4'h4, enc_hr(h, bin, h24));
        bus_write(4'h6, enc(dw, bin));
        bus_write(4'h7, enc(d, bin));
        bus_write(4'h8, enc(mo, bin));
        bus_write(4'h9, enc(y, bin));
        set_mode(1'b1, bin, h24);
    endtask

    task automatic set_alarm(input int h, input int m, input int s);
        ab_s = enc(s, mbin); ab_m = enc(m, mbin); ab_h = enc_hr(h, mbin, mh24);
        bus_write(4'h1, ab_s);
        bus_write(4'h3, ab_m);
        bus_write(4'h5, ab_h);
    endtask

    // One second: exactly P strobes, then check flag, pulses and all bytes.
    task automatic step(input string req);
        logic [7:0] d;
        bit exp_alarm;
        for (int i = 0; i < P; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
        bus_addr = 4'hA;
        @(negedge clk);
        #1 chk({"R4 in-progress flag ", req}, {7'b0, bus_rdata[7]}, {7'b0, mrun});
        @(negedge clk);
        model_tick();
        exp_alarm = mrun && enc(ms, mbin) == ab_s && enc(mm, mbin) == ab_m &&
                    enc_hr(mh, mbin, mh24) == ab_h;
        chk({"R11 update-ended ", req}, {7'b0, update_end}, {7'b0, mrun});
        chk({"R12 alarm ", req}, {7'b0, alarm_hit}, {7'b0, exp_alarm});
        @(negedge clk);
        chk({"R11 single pulse ", req}, {7'b0, update_end}, 8'h00);
        bus_read(4'h0, d); chk({"R7 seconds ", req}, d, enc(ms, mbin));
        bus_read(4'h2, d); chk({"R7 minutes ", req}, d, enc(mm, mbin));
        bus_read(4'h4, d); chk({"R9 hours ", req}, d, enc_hr(mh, mbin, mh24));
        bus_read(4'h6, d); chk({"R10 weekday ", req}, d, enc(mdw, mbin));
        bus_read(4'h7, d); chk({"R8 date ", req}, d, enc(md, mbin));
        bus_read(4'h8, d); chk({"R7 month ", req}, d, enc(mmo, mbin));
        bus_read(4'h9, d); chk({"R7 year ", req}, d, enc(my, mbin));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic [7:0] rst_exp [12];
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        mrun = 0; mbin = 0; mh24 = 1;
        ab_s = 8'h00; ab_m = 8'h00; ab_h = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset values, R1 address map
        rst_exp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h02};
        for (int a = 0; a < 12; a++) begin
            bus_read(4'(a), d);
            chk($sformatf("R3 reset addr %0h", a), d, rst_exp[a]);
        end

        // R2 seconds bit 7 dropped
        bus_write(4'h0, 8'hA5);
        bus_read(4'h0, d); chk("R2 seconds msb", d, 8'h25);
        // R1 unmapped address and status write ignored
        bus_write(4'hC, 8'h5A);
        bus_read(4'hC, d); chk("R1 unmapped reads zero", d, 8'h00);
        bus_write(4'hA, 8'hFF);
        bus_read(4'hA, d); chk("R1 status write ignored", d, 8'h00);

        // R5 halted clock
        set_time(0, 1, 10, 20, 30, 3, 15, 6, 42);
        set_mode(0, 0, 1);
        step("R5 halted");

        // R6 decimal and binary carry
        set_time(0, 1, 1, 2, 9, 1, 1, 1, 0);
        step("R6 bcd");
        bus_read(4'h0, d); chk("R6 bcd 09->10", d, 8'h10);
        set_time(1, 1, 1, 2, 9, 1, 1, 1, 0);
        step("R6 bin");
        bus_read(4'h0, d); chk("R6 bin 09->0A", d, 8'h0A);

        // R7 / R10 full chain
        set_time(0, 1, 23, 59, 59, 7, 31, 12, 99);
        step("R7 chain");
        bus_read(4'h9, d); chk("R7 year 99->00", d, 8'h00);
        bus_read(4'h6, d); chk("R10 weekday 7->1", d, 8'h01);

        // R8 month lengths
        set_time(0, 1, 23, 59, 59, 2, 28, 2, 24);
        step("R8 leap feb28");
        bus_read(4'h7, d); chk("R8 leap feb 29", d, 8'h29);
        step("R8 leap feb29");
        set_time(1, 1, 23, 59, 59, 2, 28, 2, 23);
        step("R8 common feb");
        bus_read(4'h8, d); chk("R8 common feb->mar", d, 8'h03);
        set_time(0, 1, 23, 59, 59, 5, 30, 4, 10);
        step("R8 april");

        // R9 12-hour mode
        set_time(0, 0, 11, 59, 59, 2, 10, 3, 5);
        step("R9 noon");
        bus_read(4'h4, d); chk("R9 11am->12pm", d, 8'h92);
        set_time(0, 0, 12, 59, 59, 2, 10, 3, 5);
        step("R9 one pm");
        bus_read(4'h4, d); chk("R9 12pm->1pm", d, 8'h81);
        set_time(0, 0, 23, 59, 59, 2, 10, 3, 5);
        step("R9 midnight");
        bus_read(4'h4, d); chk("R9 11pm->12am", d, 8'h12);

        // R12 alarm match and single-field mismatches
        set_time(0, 1, 8, 30, 14, 4, 9, 9, 9);
        set_alarm(8, 30, 15);
        step("R12 match");
        set_time(0, 1, 8, 30, 14, 4, 9, 9, 9);
        set_alarm(8, 31, 15);
        step("R12 minute mismatch");
        set_time(0, 1, 8, 30, 14, 4, 9, 9, 9);
        set_alarm(9, 30, 15);
        step("R12 hour mismatch");

        // Random trials
        for (int t = 0; t < 60; t++) begin
            int s, m, h, mo, y, dd, dw, dm;
            bit b, h24;
            b   = 1'($urandom % 2);
            h24 = 1'($urandom % 2);
            s   = ($urandom % 2) ? 59 : int'($urandom % 60);
            m   = ($urandom % 2) ? 59 : int'($urandom % 60);
            case ($urandom % 3)
                0:       h = 23;
                1:       h = 11;
                default: h = int'($urandom % 24);
            endcase
            mo  = 1 + int'($urandom % 12);
            y   = int'($urandom % 100);
            dm  = dim_f(mo, y);
            dd  = ($urandom % 2) ? dm : 1 + int'($urandom % dm);
            dw  = 1 + int'($urandom % 7);
            set_time(b, h24, h, m, s, dw, dd, mo, y);
            if (s < 59 && ($urandom % 2)) set_alarm(h, m, s + 1);
            else set_alarm(int'($urandom % 24), int'($urandom % 60), int'($urandom % 60));
            step($sformatf("R6 random %0d", t));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule